// File: doc/BRIEF.md
# Video Mode Frame Timing Sequencer

This block paces the frames of a serial display link host that runs in video mode. Software fills a bank of configuration inputs with horizontal durations, counted in lane byte clock cycles, and vertical durations, counted in lines. The sequencer then walks each frame in a fixed order: sync lines, back porch lines, active lines and front porch lines. Within every line it walks sync, back porch, active and front porch. It reports which region is current and emits the strobes that a packet builder downstream needs: line start, sync end, and a request for one active pixel packet per active line together with its pixel count.

For every blanking region it also reports whether the link may drop to low power, and whether a command may go out in low power there. Three transmission styles are supported: non-burst with sync pulses, non-burst with sync events, and burst. Burst compresses the active data so that the rest of the line counts as blanking. The sync and data-enable levels each have their own polarity control. The block stays idle while powered down or in command mode. Timing changes take effect only at a frame boundary, so a write in the middle of a frame never tears the frame.

Top module: `vid_timing_seq`

## Requirements
- R1: While power_up is 0 or cmd_mode is 1, from the next cycle on, line_cnt_o is 0, every strobe (sync_start_o, sync_end_o, pkt_req_o, frame_start_o) is 0, lp_ok_o and lp_cmd_ok_o are 0, and hsync_o, vsync_o and de_o rest at their inactive level. In the cycle after the clock edge that first sees power_up=1 and cmd_mode=0, the sequencer is at line 0, position 0, and frame_start_o is 1.
- R2: A line lasts hline_time cycles. h_region_o is 0 (sync) for the first hsa_time cycles, then 1 (back porch) for hbp_time cycles, then 2 (active), then 3 (front porch) for the remainder of the line.
- R3: A frame holds vsa+vbp+vact+vfp lines. v_region_o is 0 on sync lines, 1 on back porch lines, 2 on active lines and 3 on front porch lines, in that order. line_cnt_o counts 0 up to total-1 and wraps. frame_start_o is 1 exactly at line 0, position 0.
- R4: For vid_type 0, 1 and 3, the active region lasts pkt_pixels_cfg cycles on every line. De is asserted only in the active region of active lines. pkt_req_o pulses for one cycle in the first active cycle of each active line. pkt_size_o carries the frame's pixel count.
- R5: For vid_type 2 (burst), the active region lasts one cycle, in which both de and pkt_req_o are asserted. The rest of the line is reported as front porch.
- R6: sync_start_o pulses at position 0 of every line in every mode. sync_end_o pulses at position hsa_time only when vid_type is 0. vid_type 3 behaves as vid_type 1.
- R7: lp_ok_o follows lp_region_en. Bit 0 covers the sync lines, bit 1 the back porch lines and bit 2 the front porch lines. On active lines, bit 5 covers the horizontal sync region, bit 3 the horizontal back porch and bit 4 the horizontal front porch. lp_ok_o is 0 in the active region.
- R8: lp_cmd_ok_o equals lp_ok_o AND lp_cmd_en.
- R9: pol_ctl bit 0 inverts de_o, bit 1 inverts vsync_o and bit 2 inverts hsync_o. The polarity bits take effect at once. Raw hsync is high in the horizontal sync region, and raw vsync is high on sync lines.
- R10: All timing, mode, size and low-power settings are captured only at the start of a frame. A change made during a frame first shows in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane byte clock |
| rst | input | 1 | Synchronous active-high reset |
| power_up | input | 1 | 0 holds the sequencer idle |
| cmd_mode | input | 1 | 1 selects command mode (sequencer idle), 0 selects video mode |
| vid_type | input | 2 | 0 sync pulses, 1 sync events, 2 burst, 3 treated as 1 |
| hsa_time | input | 12 | Horizontal sync time in lane byte cycles |
| hbp_time | input | 12 | Horizontal back porch time in lane byte cycles |
| hline_time | input | 12 | Total line time in lane byte cycles |
| vsa_lines | input | 10 | Vertical sync lines |
| vbp_lines | input | 10 | Vertical back porch lines |
| vact_lines | input | 10 | Active lines |
| vfp_lines | input | 10 | Vertical front porch lines |
| pkt_pixels_cfg | input | 14 | Pixel count of each active packet |
| lp_region_en | input | 6 | Low-power enable, one bit per blanking region |
| lp_cmd_en | input | 1 | Allow low-power commands during video |
| pol_ctl | input | 3 | Active-low select: bit 0 de, bit 1 vsync, bit 2 hsync |
| hsync_o | output | 1 | Horizontal sync level |
| vsync_o | output | 1 | Vertical sync level |
| de_o | output | 1 | Data enable level |
| h_region_o | output | 2 | Horizontal region code |
| v_region_o | output | 2 | Vertical region code |
| sync_start_o | output | 1 | Line start strobe |
| sync_end_o | output | 1 | Sync end strobe (sync-pulse mode only) |
| pkt_req_o | output | 1 | Active packet request |
| pkt_size_o | output | 14 | Pixel count for the requested packet |
| lp_ok_o | output | 1 | Low power allowed now |
| lp_cmd_ok_o | output | 1 | Low-power command allowed now |
| line_cnt_o | output | 12 | Line number within the frame |
| frame_start_o | output | 1 | First cycle of a frame |

## Verification
The assertions assume well-formed timing. Every duration is at least 1. Each active line fits its content: hsa_time+hbp_time+pkt_pixels_cfg does not exceed hline_time, and the line total of the four vertical counts is at least 1. The bench only ever programs values derived to meet these bounds, with a front porch of at least two cycles. The sweep covers all four type codes under all eight polarity settings. One test changes the settings partway through a frame, and the bench predicts that the change takes effect at the following frame boundary.

// File: rtl/vts_pkg.sv
package vts_pkg;
    parameter int HW  = 12;
    parameter int VW  = 10;
    parameter int PW  = 14;
    parameter int LPW = 6;
    parameter int NPOL = 3;

    localparam int LW = VW + 2;
    localparam int SW = ((PW > HW) ? PW : HW) + 2;

    typedef enum logic [1:0] {
        RG_SYNC  = 2'd0,
        RG_BACK  = 2'd1,
        RG_ACTV  = 2'd2,
        RG_FRONT = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        VT_PULSE = 2'd0,
        VT_EVENT = 2'd1,
        VT_BURST = 2'd2,
        VT_RSVD  = 2'd3
    } vtype_e;

    typedef struct packed {
        vtype_e           vtype;
        logic [HW-1:0]    hsa;
        logic [HW-1:0]    hbp;
        logic [HW-1:0]    hline;
        logic [VW-1:0]    vsa;
        logic [VW-1:0]    vbp;
        logic [VW-1:0]    vact;
        logic [VW-1:0]    vfp;
        logic [PW-1:0]    pkt;
        logic [LPW-1:0]   lp_en;
        logic             lp_cmd;
    } cfg_t;

    function automatic region_e classify(input logic [SW-1:0] pos,
                                         input logic [SW-1:0] b0,
                                         input logic [SW-1:0] b1,
                                         input logic [SW-1:0] b2);
        if (pos < b0)      return RG_SYNC;
        else if (pos < b1) return RG_BACK;
        else if (pos < b2) return RG_ACTV;
        else               return RG_FRONT;
    endfunction
endpackage

// File: rtl/vts_shadow.sv
module vts_shadow
    import vts_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  cfg_t cfg_i,
    output cfg_t cfg_o
);
    always_ff @(posedge clk) begin
        if (rst)       cfg_o <= '0;
        else if (load) cfg_o <= cfg_i;
    end
endmodule

// File: rtl/vts_counters.sv
module vts_counters
    import vts_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  cfg_t          cfg,
    output logic          started,
    output logic [HW-1:0] hpos,
    output logic [LW-1:0] line,
    output logic          load
);
    logic [LW-1:0] total;
    logic          h_last;
    logic          l_last;

    assign total  = LW'(cfg.vsa) + LW'(cfg.vbp) + LW'(cfg.vact) + LW'(cfg.vfp);
    assign h_last = (hpos == cfg.hline - HW'(1));
    assign l_last = (line == total - LW'(1));
    assign load   = run && (!started || (h_last && l_last));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            started <= 1'b0;
            hpos    <= '0;
            line    <= '0;
        end else if (!started) begin
            started <= 1'b1;
            hpos    <= '0;
            line    <= '0;
        end else if (h_last) begin
            hpos <= '0;
            line <= l_last ? '0 : line + LW'(1);
        end else begin
            hpos <= hpos + HW'(1);
        end
    end
endmodule

// File: rtl/vts_decode.sv
module vts_decode
    import vts_pkg::*;
(
    input  logic          started,
    input  logic [HW-1:0] hpos,
    input  logic [LW-1:0] line,
    input  cfg_t          cfg,
    output region_e       h_region,
    output region_e       v_region,
    output logic          raw_hs,
    output logic          raw_vs,
    output logic          raw_de,
    output logic          sync_start,
    output logic          sync_end,
    output logic          pkt_req,
    output logic          lp_ok,
    output logic          lp_cmd_ok,
    output logic          frame_start
);
    logic [SW-1:0] h_b0, h_b1, h_b2, hp;
    logic [SW-1:0] v_b0, v_b1, v_b2, lp;
    logic          burst;
    logic          act_line;
    logic          lp_sel;

    assign burst = (cfg.vtype == VT_BURST);
    assign hp    = SW'(hpos);
    assign lp    = SW'(line);
    assign h_b0  = SW'(cfg.hsa);
    assign h_b1  = h_b0 + SW'(cfg.hbp);
    assign h_b2  = burst ? (h_b1 + SW'(1)) : (h_b1 + SW'(cfg.pkt));
    assign v_b0  = SW'(cfg.vsa);
    assign v_b1  = v_b0 + SW'(cfg.vbp);
    assign v_b2  = v_b1 + SW'(cfg.vact);

    assign h_region = classify(hp, h_b0, h_b1, h_b2);
    assign v_region = classify(lp, v_b0, v_b1, v_b2);
    assign act_line = (v_region == RG_ACTV);

    always_comb begin
        lp_sel = 1'b0;
        unique case (v_region)
            RG_SYNC:  lp_sel = cfg.lp_en[0];
            RG_BACK:  lp_sel = cfg.lp_en[1];
            RG_FRONT: lp_sel = cfg.lp_en[2];
            RG_ACTV: begin
                unique case (h_region)
                    RG_SYNC:  lp_sel = cfg.lp_en[5];
                    RG_BACK:  lp_sel = cfg.lp_en[3];
                    RG_FRONT: lp_sel = cfg.lp_en[4];
                    RG_ACTV:  lp_sel = 1'b0;
                endcase
            end
        endcase
    end

    assign raw_hs      = started && (h_region == RG_SYNC);
    assign raw_vs      = started && (v_region == RG_SYNC);
    assign raw_de      = started && act_line && (h_region == RG_ACTV);
    assign pkt_req     = started && act_line && (hp == h_b1);
    assign sync_start  = started && (hpos == '0);
    assign sync_end    = started && (cfg.vtype == VT_PULSE) && (hp == h_b0);
    assign lp_ok       = started && lp_sel;
    assign lp_cmd_ok   = lp_ok && cfg.lp_cmd;
    assign frame_start = started && (hpos == '0) && (line == '0);
endmodule

// File: rtl/vts_polarity.sv
module vts_polarity
    import vts_pkg::*;
(
    input  logic [NPOL-1:0] raw,
    input  logic [NPOL-1:0] pol,
    output logic [NPOL-1:0] lvl
);
    for (genvar i = 0; i < NPOL; i++) begin : g_pol
        assign lvl[i] = raw[i] ^ pol[i];
    end
endmodule

// File: rtl/vid_timing_seq.sv
module vid_timing_seq
    import vts_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 power_up,
    input  logic                 cmd_mode,
    input  logic [1:0]           vid_type,
    input  logic [HW-1:0]        hsa_time,
    input  logic [HW-1:0]        hbp_time,
    input  logic [HW-1:0]        hline_time,
    input  logic [VW-1:0]        vsa_lines,
    input  logic [VW-1:0]        vbp_lines,
    input  logic [VW-1:0]        vact_lines,
    input  logic [VW-1:0]        vfp_lines,
    input  logic [PW-1:0]        pkt_pixels_cfg,
    input  logic [LPW-1:0]       lp_region_en,
    input  logic                 lp_cmd_en,
    input  logic [NPOL-1:0]      pol_ctl,
    output logic                 hsync_o,
    output logic                 vsync_o,
    output logic                 de_o,
    output logic [1:0]           h_region_o,
    output logic [1:0]           v_region_o,
    output logic                 sync_start_o,
    output logic                 sync_end_o,
    output logic                 pkt_req_o,
    output logic [PW-1:0]        pkt_size_o,
    output logic                 lp_ok_o,
    output logic                 lp_cmd_ok_o,
    output logic [LW-1:0]        line_cnt_o,
    output logic                 frame_start_o
);
    cfg_t          cfg_in;
    cfg_t          sh;
    logic          run;
    logic          load;
    logic          started;
    logic [HW-1:0] hpos;
    logic [LW-1:0] line;
    region_e       h_reg, v_reg;
    logic          raw_hs, raw_vs, raw_de;
    logic [NPOL-1:0] lvl;

    assign run = power_up && !cmd_mode;

    always_comb begin
        cfg_in.vtype  = vtype_e'(vid_type);
        cfg_in.hsa    = hsa_time;
        cfg_in.hbp    = hbp_time;
        cfg_in.hline  = hline_time;
        cfg_in.vsa    = vsa_lines;
        cfg_in.vbp    = vbp_lines;
        cfg_in.vact   = vact_lines;
        cfg_in.vfp    = vfp_lines;
        cfg_in.pkt    = pkt_pixels_cfg;
        cfg_in.lp_en  = lp_region_en;
        cfg_in.lp_cmd = lp_cmd_en;
    end

    vts_shadow u_shadow (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .cfg_i (cfg_in),
        .cfg_o (sh)
    );

    vts_counters u_cnt (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .cfg     (sh),
        .started (started),
        .hpos    (hpos),
        .line    (line),
        .load    (load)
    );

    vts_decode u_dec (
        .started     (started),
        .hpos        (hpos),
        .line        (line),
        .cfg         (sh),
        .h_region    (h_reg),
        .v_region    (v_reg),
        .raw_hs      (raw_hs),
        .raw_vs      (raw_vs),
        .raw_de      (raw_de),
        .sync_start  (sync_start_o),
        .sync_end    (sync_end_o),
        .pkt_req     (pkt_req_o),
        .lp_ok       (lp_ok_o),
        .lp_cmd_ok   (lp_cmd_ok_o),
        .frame_start (frame_start_o)
    );

    vts_polarity u_pol (
        .raw (3'({raw_hs, raw_vs, raw_de})),
        .pol (pol_ctl),
        .lvl (lvl)
    );

    assign de_o       = lvl[0];
    assign vsync_o    = lvl[1];
    assign hsync_o    = lvl[2];
    assign h_region_o = h_reg;
    assign v_region_o = v_reg;
    assign pkt_size_o = sh.pkt;
    assign line_cnt_o = line;
endmodule

// File: rtl/vid_timing_seq_chk.sv
module vid_timing_seq_chk
    import vts_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          run,
    input cfg_t          sh,
    input logic [LW-1:0] line_cnt,
    input logic          pkt_req,
    input logic          frame_start,
    input logic          sync_start,
    input logic          sync_end,
    input logic [1:0]    h_region,
    input logic          lp_ok,
    input logic          lp_cmd_ok,
    input logic          de_lvl,
    input logic          de_pol
);
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !run |=> (line_cnt == '0 && !pkt_req && !frame_start && !lp_ok)); // R1

    AST_FRAME_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (line_cnt == '0 && sync_start && h_region == RG_SYNC)); // R3

    AST_PKT_WITH_DE: assert property (@(posedge clk) disable iff (rst)
        pkt_req |-> (de_lvl ^ de_pol)); // R4

    AST_BURST_SHORT: assert property (@(posedge clk) disable iff (rst)
        (pkt_req && sh.vtype == VT_BURST) |=> (h_region != RG_ACTV)); // R5

    AST_SYNC_END_MODE: assert property (@(posedge clk) disable iff (rst)
        sync_end |-> (sh.vtype == VT_PULSE)); // R6

    AST_LPCMD_SUBSET: assert property (@(posedge clk) disable iff (rst)
        lp_cmd_ok |-> lp_ok); // R8

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$stable(sh) |-> frame_start); // R10
endmodule

bind vid_timing_seq vid_timing_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .run         (run),
    .sh          (sh),
    .line_cnt    (line_cnt_o),
    .pkt_req     (pkt_req_o),
    .frame_start (frame_start_o),
    .sync_start  (sync_start_o),
    .sync_end    (sync_end_o),
    .h_region    (h_region_o),
    .lp_ok       (lp_ok_o),
    .lp_cmd_ok   (lp_cmd_ok_o),
    .de_lvl      (de_o),
    .de_pol      (pol_ctl[0])
);

// File: tb/vid_timing_seq_bench.sv
`timescale 1ns/1ps
module vid_timing_seq_bench;
    import vts_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic power_up = 1'b0;
    logic cmd_mode = 1'b0;
    logic [NPOL-1:0] pol = '0;
    cfg_t drv = '0;
    cfg_t mcfg = '0;

    logic hsync_o, vsync_o, de_o, sync_start_o, sync_end_o, pkt_req_o;
    logic lp_ok_o, lp_cmd_ok_o, frame_start_o;
    logic [1:0] h_region_o, v_region_o;
    logic [PW-1:0] pkt_size_o;
    logic [LW-1:0] line_cnt_o;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    vid_timing_seq u_vid_timing_seq (
        .clk(clk), .rst(rst), .power_up(power_up), .cmd_mode(cmd_mode),
        .vid_type(drv.vtype), .hsa_time(drv.hsa), .hbp_time(drv.hbp),
        .hline_time(drv.hline), .vsa_lines(drv.vsa), .vbp_lines(drv.vbp),
        .vact_lines(drv.vact), .vfp_lines(drv.vfp), .pkt_pixels_cfg(drv.pkt),
        .lp_region_en(drv.lp_en), .lp_cmd_en(drv.lp_cmd), .pol_ctl(pol),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .h_region_o(h_region_o), .v_region_o(v_region_o),
        .sync_start_o(sync_start_o), .sync_end_o(sync_end_o),
        .pkt_req_o(pkt_req_o), .pkt_size_o(pkt_size_o),
        .lp_ok_o(lp_ok_o), .lp_cmd_ok_o(lp_cmd_ok_o),
        .line_cnt_o(line_cnt_o), .frame_start_o(frame_start_o)
    );

    task automatic chk(input string tag, input int got, input int exp);
        nchk++;
        if (got != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, got, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    function automatic int tot_lines(input cfg_t c);
        return int'(c.vsa) + int'(c.vbp) + int'(c.vact) + int'(c.vfp);
    endfunction

    task automatic check_pos(input int h, input int ln);
        int b0, b1, b2, v0, v1, v2, hr, vr, lpx;
        bit burst, ea, exp_de, exp_pk;
        burst = (mcfg.vtype == 2'd2);
        b0 = int'(mcfg.hsa);
        b1 = b0 + int'(mcfg.hbp);
        b2 = burst ? b1 + 1 : b1 + int'(mcfg.pkt);
        v0 = int'(mcfg.vsa);
        v1 = v0 + int'(mcfg.vbp);
        v2 = v1 + int'(mcfg.vact);
        hr = (h < b0) ? 0 : (h < b1) ? 1 : (h < b2) ? 2 : 3;
        vr = (ln < v0) ? 0 : (ln < v1) ? 1 : (ln < v2) ? 2 : 3;
        ea = (vr == 2);
        exp_de = ea && (hr == 2);
        exp_pk = ea && (h == b1);
        case (vr)
            0: lpx = mcfg.lp_en[0];
            1: lpx = mcfg.lp_en[1];
            3: lpx = mcfg.lp_en[2];
            default: lpx = (hr == 0) ? mcfg.lp_en[5] : (hr == 1) ? mcfg.lp_en[3] :
                           (hr == 3) ? mcfg.lp_en[4] : 0;
        endcase
        chk("R2 h_region", int'(h_region_o), hr);
        chk("R3 v_region", int'(v_region_o), vr);
        chk("R3 line_cnt", int'(line_cnt_o), ln);
        chk("R3 frame_start", int'(frame_start_o), int'(h == 0 && ln == 0));
        if (burst) begin
            chk("R5 de", int'(de_o), int'(exp_de ^ pol[0]));
            chk("R5 pkt_req", int'(pkt_req_o), int'(exp_pk));
        end else begin
            chk("R4 de", int'(de_o), int'(exp_de ^ pol[0]));
            chk("R4 pkt_req", int'(pkt_req_o), int'(exp_pk));
        end
        chk("R4 pkt_size", int'(pkt_size_o), int'(mcfg.pkt));
        chk("R6 sync_start", int'(sync_start_o), int'(h == 0));
        chk("R6 sync_end", int'(sync_end_o), int'(mcfg.vtype == 2'd0 && h == b0));
        chk("R7 lp_ok", int'(lp_ok_o), lpx);
        chk("R8 lp_cmd_ok", int'(lp_cmd_ok_o), lpx & int'(mcfg.lp_cmd));
        chk("R9 hsync", int'(hsync_o), int'((hr == 0) ^ pol[2]));
        chk("R9 vsync", int'(vsync_o), int'((vr == 0) ^ pol[1]));
    endtask

    task automatic check_idle();
        chk("R1 line_cnt idle", int'(line_cnt_o), 0);
        chk("R1 strobes idle", int'({sync_start_o, sync_end_o, pkt_req_o, frame_start_o}), 0);
        chk("R1 lp idle", int'({lp_ok_o, lp_cmd_ok_o}), 0);
        chk("R1 levels idle", int'({hsync_o, vsync_o, de_o}), int'(pol));
    endtask

    // Runs ncyc cycles from a fresh start; optionally swaps to alt at cycle swap_at.
    task automatic run_seq(input int ncyc, input int swap_at, input cfg_t alt);
        int h, ln;
        power_up = 1'b1;
        mcfg = drv;
        @(negedge clk);
        h = 0;
        ln = 0;
        for (int k = 0; k < ncyc; k++) begin
            check_pos(h, ln);
            if (k == swap_at) drv = alt;
            h++;
            if (h == int'(mcfg.hline)) begin
                h = 0;
                ln++;
                if (ln == tot_lines(mcfg)) begin
                    ln = 0;
                    mcfg = drv;
                end
            end
            @(negedge clk);
        end
        power_up = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_idle();
    endtask

    function automatic cfg_t make_cfg(input int t, input int p);
        cfg_t c;
        c.vtype  = vtype_e'(t);
        c.hsa    = HW'(1 + p % 3);
        c.hbp    = HW'(1 + t);
        c.pkt    = PW'(3 + p);
        c.hline  = HW'(int'(c.hsa) + int'(c.hbp) + int'(c.pkt) + 2 + t);
        c.vsa    = VW'(1 + p % 2);
        c.vbp    = VW'(1);
        c.vact   = VW'(2 + t % 2);
        c.vfp    = VW'(1 + p / 4);
        c.lp_en  = LPW'(((t * 8 + p) * 5 + 11) % 64);
        c.lp_cmd = p[0];
        return c;
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_idle();

        // Sweep every type code against every polarity setting.
        for (int t = 0; t < 4; t++) begin
            for (int p = 0; p < 8; p++) begin
                drv = make_cfg(t, p);
                pol = NPOL'(p);
                run_seq(tot_lines(drv) * int'(drv.hline) + int'(drv.hline) + 3, -1, drv);
            end
        end

        // R1: command mode keeps the sequencer idle even when powered.
        drv = make_cfg(0, 5);
        pol = 3'b101;
        cmd_mode = 1'b1;
        power_up = 1'b1;
        repeat (3) @(negedge clk);
        check_idle();
        power_up = 1'b0;
        cmd_mode = 1'b0;
        @(negedge clk);

        // R10: a mid-frame change lands at the next frame boundary.
        drv = make_cfg(0, 2);
        pol = 3'b000;
        run_seq(3 * tot_lines(drv) * int'(drv.hline), 17, make_cfg(2, 6));

        // R9: polarity change applied while running takes effect at once.
        drv = make_cfg(1, 1);
        pol = 3'b000;
        power_up = 1'b1;
        @(negedge clk);
        pol = 3'b111;
        #0.1;
        chk("R9 live polarity hsync", int'(hsync_o), 0);
        chk("R9 live polarity vsync", int'(vsync_o), 0);
        power_up = 1'b0;
        @(negedge clk);
        @(negedge clk);

        finish_run();
    end
endmodule